// File: doc/BRIEF.md
# Multi-cell battery protection sequencer

A digital sequencer that guards a series stack of three or four lithium-ion cells. On every sample tick it walks the cells one per clock cycle, folding four comparator flags per cell (above overcharge, above overcharge-release, below undercharge, above undercharge-release) into a summary. A state machine then decides the charge-switch and discharge-switch enables. An overcharge or undercharge fault must be seen on consecutive samples before it acts. Analog comparators, cell sampling and gate drive sit outside the block as plain digital flags.

In overcharge the charge switch is held off until every cell drops below the release level. While a discharge current is sensed, the switch is reopened so the load does not run through the body diode. An undercharge fault shuts both switches and puts the block to sleep. A charger on the wake input starts a one-sample charge burst, which ends either in the normal state or back in sleep. The sample tick comes from a prescaler on the system clock or from an external tick input.

Top module: `cell_guard`

## Requirements
- R1: After reset the block is in the normal state: sleep_o=0, dsg_on_o=1, chg_on_o equals chg_en_i.
- R2: With cell_cnt_i=1 (three-cell) the flags of the top cell (index NCELL-1) are ignored; with cell_cnt_i=0 (four-cell) all NCELL cells are evaluated.
- R3: An overcharge flag seen on one sample leaves chg_on_o high; the same flag on QUAL=2 consecutive samples turns chg_on_o off. Each sample's effect shows NCELL+2 clock edges after the tick edge.
- R4: In overcharge, chg_on_o stays off until a sample in which no counted cell raises its above-overcharge-release flag; that sample restores the normal state.
- R5: In overcharge, chg_on_o follows dsg_sense_i (gated by chg_en_i) in the same cycle, while dsg_on_o stays 1.
- R6: An undercharge flag on QUAL consecutive samples forces chg_on_o=0, dsg_on_o=0 and sleep_o=1.
- R7: When undercharge and overcharge qualify on the same sample, the block enters sleep.
- R8: In sleep, sample ticks are ignored; wake_i high moves the block to the burst state at the next edge with dsg_on_o=1 and chg_on_o=chg_en_i.
- R9: The sample that ends a burst goes to normal if every counted cell raises its above-undercharge-release flag, and back to sleep otherwise.
- R10: chg_on_o is 0 in every state whenever chg_en_i is 0.
- R11: With tick_i held low, one sample is taken every PRESCALE clock cycles after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | External sample tick, ORed with the prescaler tick |
| cell_cnt_i | input | 1 | 0 selects four cells, 1 selects three |
| ov_i | input | NCELL | Cell above overcharge threshold |
| ovr_i | input | NCELL | Cell above overcharge-release threshold |
| uv_i | input | NCELL | Cell below undercharge threshold |
| uvr_i | input | NCELL | Cell above undercharge-release threshold |
| chg_en_i | input | 1 | Charge permission |
| wake_i | input | 1 | Charger present |
| dsg_sense_i | input | 1 | Discharge current above the small threshold |
| chg_on_o | output | 1 | Charge switch enable |
| dsg_on_o | output | 1 | Discharge switch enable |
| sleep_o | output | 1 | Low-power sleep state |

## Verification
A sample's effect on the switch outputs is due NCELL+2 edges after the tick edge: the tick starts the scan, NCELL edges walk the cells and one edge moves the state. The bench holds the cell flags steady across that window and reads the outputs eight cycles after the tick. A wake takes effect at the next edge and is checked one cycle later. The charge-enable and discharge-sense gating act in the same cycle and are checked one nanosecond after the input changes. The prescaler check waits just past one and then two full periods from reset.

// File: rtl/cell_guard_pkg.sv
package cell_guard_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL = 2'd0,
    ST_OVCHG  = 2'd1,
    ST_SLEEP  = 2'd2,
    ST_BURST  = 2'd3
  } guard_state_e;

  typedef struct packed {
    logic any_ov;
    logic any_above_ovr;
    logic any_uv;
    logic all_above_uvr;
  } scan_sum_t;
endpackage

// File: rtl/cg_tick_gen.sv
module cg_tick_gen #(
  parameter int unsigned PRESCALE = 2125000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic ext_tick_i,
  output logic tick_o
);
  localparam int unsigned CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap = (cnt_q == CW'(PRESCALE - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (restart_i || wrap) cnt_q <= '0;
    else                        cnt_q <= cnt_q + CW'(1);
  end

  assign tick_o = (wrap & ~restart_i) | ext_tick_i;
endmodule

// File: rtl/cg_cell_scan.sv
module cg_cell_scan
  import cell_guard_pkg::*;
#(
  parameter int unsigned NCELL = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             three_i,
  input  logic [NCELL-1:0] ov_i,
  input  logic [NCELL-1:0] ovr_i,
  input  logic [NCELL-1:0] uv_i,
  input  logic [NCELL-1:0] uvr_i,
  output logic             valid_o,
  output scan_sum_t        sum_o
);
  localparam int unsigned IW = (NCELL > 1) ? $clog2(NCELL) : 1;
  localparam logic [IW-1:0] LAST = IW'(NCELL - 1);

  logic          busy_q, valid_q;
  logic [IW-1:0] idx_q;
  scan_sum_t     acc_q, acc_n, sum_q;
  logic          skip, last;

  assign skip = three_i && (idx_q == LAST);
  assign last = (idx_q == LAST);

  always_comb begin
    acc_n = acc_q;
    if (!skip) begin
      acc_n.any_ov        = acc_q.any_ov        | ov_i[idx_q];
      acc_n.any_above_ovr = acc_q.any_above_ovr | ovr_i[idx_q];
      acc_n.any_uv        = acc_q.any_uv        | uv_i[idx_q];
      acc_n.all_above_uvr = acc_q.all_above_uvr & uvr_i[idx_q];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      idx_q   <= '0;
      acc_q   <= '0;
      sum_q   <= '0;
    end else begin
      valid_q <= 1'b0;
      if (busy_q) begin
        acc_q <= acc_n;
        idx_q <= idx_q + IW'(1);
        if (last) begin
          busy_q  <= 1'b0;
          valid_q <= 1'b1;
          sum_q   <= acc_n;
        end
      end else if (tick_i && en_i) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        acc_q  <= '{any_ov: 1'b0, any_above_ovr: 1'b0, any_uv: 1'b0, all_above_uvr: 1'b1};
      end
    end
  end

  assign valid_o = valid_q;
  assign sum_o   = sum_q;

  // R3: one summary per scan
  a_r3_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  // R3: a summary only closes a running scan
  a_r3_valid_after_scan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_q) |-> $past(busy_q) && !busy_q);
endmodule

// File: rtl/cg_guard_fsm.sv
module cg_guard_fsm
  import cell_guard_pkg::*;
#(
  parameter int unsigned QUAL = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      valid_i,
  input  scan_sum_t sum_i,
  input  logic      wake_i,
  input  logic      chg_en_i,
  input  logic      dsg_sense_i,
  output logic      wake_start_o,
  output logic      chg_on_o,
  output logic      dsg_on_o,
  output logic      sleep_o
);
  localparam int unsigned CW = $clog2(QUAL + 1);
  localparam logic [CW-1:0] QMAX = CW'(QUAL);

  guard_state_e  state_q, st_n;
  logic [CW-1:0] uv_q, ov_q, uv_n, ov_n;

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
    return (v == QMAX) ? v : v + CW'(1);
  endfunction

  always_comb begin
    st_n = state_q;
    uv_n = uv_q;
    ov_n = ov_q;
    unique case (state_q)
      ST_NORMAL, ST_OVCHG: if (valid_i) begin
        uv_n = sum_i.any_uv ? sat_inc(uv_q) : '0;
        ov_n = (state_q == ST_NORMAL && sum_i.any_ov) ? sat_inc(ov_q) : '0;
        if (uv_n == QMAX) begin            // undercharge wins
          st_n = ST_SLEEP;
          uv_n = '0;
          ov_n = '0;
        end else if (state_q == ST_NORMAL && ov_n == QMAX) begin
          st_n = ST_OVCHG;
          uv_n = '0;
          ov_n = '0;
        end else if (state_q == ST_OVCHG && !sum_i.any_above_ovr) begin
          st_n = ST_NORMAL;
          uv_n = '0;
        end
      end
      ST_SLEEP: if (wake_i) st_n = ST_BURST;
      ST_BURST: if (valid_i) st_n = sum_i.all_above_uvr ? ST_NORMAL : ST_SLEEP;
      default:  st_n = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_NORMAL;
      uv_q    <= '0;
      ov_q    <= '0;
    end else begin
      state_q <= st_n;
      uv_q    <= uv_n;
      ov_q    <= ov_n;
    end
  end

  assign chg_on_o = chg_en_i & ((state_q == ST_NORMAL) | (state_q == ST_BURST) |
                                ((state_q == ST_OVCHG) & dsg_sense_i));
  assign dsg_on_o = (state_q != ST_SLEEP);
  assign sleep_o  = (state_q == ST_SLEEP);
  assign wake_start_o = (state_q == ST_SLEEP) && wake_i;

  // R3: overcharge entry only after QUAL qualifying samples
  a_r3_ov_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OVCHG && $past(state_q) == ST_NORMAL) |->
      ($past(valid_i) && $past(ov_q) == CW'(QUAL - 1)));
  // R6: sleep entry from an active state only after QUAL undercharge samples
  a_r6_uv_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SLEEP && ($past(state_q) == ST_NORMAL || $past(state_q) == ST_OVCHG)) |->
      ($past(valid_i) && $past(uv_q) == CW'(QUAL - 1)));
  // R8: burst only follows a wake in sleep
  a_r8_burst_from_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BURST && $past(state_q) != ST_BURST) |->
      ($past(state_q) == ST_SLEEP && $past(wake_i)));
  // R9: burst ends in normal only on a full release sample
  a_r9_burst_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_NORMAL && $past(state_q) == ST_BURST) |->
      ($past(valid_i) && $past(sum_i.all_above_uvr)));
endmodule

// File: rtl/cell_guard.sv
module cell_guard
  import cell_guard_pkg::*;
#(
  parameter int unsigned NCELL    = 4,
  parameter int unsigned PRESCALE = 2125000,
  parameter int unsigned QUAL     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cell_cnt_i,
  input  logic [NCELL-1:0] ov_i,
  input  logic [NCELL-1:0] ovr_i,
  input  logic [NCELL-1:0] uv_i,
  input  logic [NCELL-1:0] uvr_i,
  input  logic             chg_en_i,
  input  logic             wake_i,
  input  logic             dsg_sense_i,
  output logic             chg_on_o,
  output logic             dsg_on_o,
  output logic             sleep_o
);
  logic      tick, restart, valid;
  scan_sum_t sum;

  cg_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
    .clk_i, .rst_ni, .restart_i(restart), .ext_tick_i(tick_i), .tick_o(tick)
  );

  cg_cell_scan #(.NCELL(NCELL)) u_scan (
    .clk_i, .rst_ni, .en_i(!sleep_o), .tick_i(tick), .three_i(cell_cnt_i),
    .ov_i, .ovr_i, .uv_i, .uvr_i, .valid_o(valid), .sum_o(sum)
  );

  cg_guard_fsm #(.QUAL(QUAL)) u_fsm (
    .clk_i, .rst_ni, .valid_i(valid), .sum_i(sum), .wake_i, .chg_en_i, .dsg_sense_i,
    .wake_start_o(restart), .chg_on_o, .dsg_on_o, .sleep_o
  );

  // R6: sleep holds both switches open
  a_r6_sleep_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_o |-> (!chg_on_o && !dsg_on_o));
  // R5: discharge switch never opens outside sleep
  a_r5_dsg_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_o |-> dsg_on_o);
endmodule

// File: tb/sim_cell_guard.sv
module sim_cell_guard;
  localparam int NC = 4;
  localparam int PS = 40000;
  localparam int QL = 2;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, cnt3 = 1'b0;
  logic [NC-1:0] ov = '0, ovr = '0, uv = '0, uvr = '1;
  logic chg_en = 1'b1, wake = 1'b0, sense = 1'b0;
  logic chg_on, dsg_on, slp;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  int m_st = 0, m_uv = 0, m_ov = 0;   // 0 normal, 1 overcharge, 2 sleep, 3 burst

  always #2 clk = ~clk;

  cell_guard #(.NCELL(NC), .PRESCALE(PS), .QUAL(QL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .cell_cnt_i(cnt3),
    .ov_i(ov), .ovr_i(ovr), .uv_i(uv), .uvr_i(uvr), .chg_en_i(chg_en),
    .wake_i(wake), .dsg_sense_i(sense), .chg_on_o(chg_on), .dsg_on_o(dsg_on), .sleep_o(slp)
  );

  task automatic chk(input logic got, input logic exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0b exp=%0b", tag, got, exp);
    end
  endtask

  function automatic logic exp_chg();
    return chg_en && (m_st == 0 || m_st == 3 || (m_st == 1 && sense));
  endfunction

  task automatic chk_all(input string tag);
    chk(chg_on, exp_chg(), {tag, " chg"});
    chk(dsg_on, m_st != 2, {tag, " dsg"});
    chk(slp, m_st == 2, {tag, " sleep"});
  endtask

  task automatic model_sample();
    logic a_ov = 0, a_ovr = 0, a_uv = 0, all_uvr = 1;
    for (int i = 0; i < NC; i++) begin
      if (!(cnt3 && i == NC - 1)) begin
        a_ov |= ov[i]; a_ovr |= ovr[i]; a_uv |= uv[i]; all_uvr &= uvr[i];
      end
    end
    if (m_st == 0 || m_st == 1) begin
      m_uv = a_uv ? ((m_uv == QL) ? QL : m_uv + 1) : 0;
      m_ov = (m_st == 0 && a_ov) ? ((m_ov == QL) ? QL : m_ov + 1) : 0;
      if (m_uv == QL) begin m_st = 2; m_uv = 0; m_ov = 0; end
      else if (m_st == 0 && m_ov == QL) begin m_st = 1; m_uv = 0; m_ov = 0; end
      else if (m_st == 1 && !a_ovr) begin m_st = 0; m_uv = 0; end
    end else if (m_st == 3) begin
      m_st = all_uvr ? 0 : 2;
    end
  endtask

  task automatic sample(input string tag);
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    repeat (8) @(negedge clk);
    model_sample();
    chk_all(tag);
  endtask

  task automatic do_wake(input string tag);
    @(negedge clk) wake = 1'b1;
    @(negedge clk) wake = 1'b0;
    if (m_st == 2) m_st = 3;
    chk_all(tag);
  endtask

  task automatic clear_flags();
    ov = '0; ovr = '0; uv = '0; uvr = '1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1 reset");

    // R3 qualification
    ov[1] = 1; ovr[1] = 1;
    sample("R3 one sample");
    chk(chg_on, 1'b1, "R3 still on");
    sample("R3 two samples");
    chk(chg_on, 1'b0, "R3 off");
    // R5 smart discharge
    @(negedge clk) sense = 1'b1; #1;
    chk(chg_on, 1'b1, "R5 sense on");
    chk(dsg_on, 1'b1, "R5 dsg");
    @(negedge clk) chg_en = 1'b0; #1;
    chk(chg_on, 1'b0, "R10 overcharge gate");
    @(negedge clk) begin chg_en = 1'b1; sense = 1'b0; end #1;
    chk(chg_on, 1'b0, "R5 sense off");
    // R4 hysteresis
    ov[1] = 0;
    sample("R4 band");
    chk(chg_on, 1'b0, "R4 held");
    ovr[1] = 0;
    sample("R4 release");
    chk(chg_on, 1'b1, "R4 back on");
    // R2 cell count
    cnt3 = 1'b1; ov[NC-1] = 1; ovr[NC-1] = 1;
    sample("R2 three a"); sample("R2 three b");
    chk(chg_on, 1'b1, "R2 top cell ignored");
    cnt3 = 1'b0;
    sample("R2 four a"); sample("R2 four b");
    chk(chg_on, 1'b0, "R2 top cell counted");
    clear_flags();
    sample("R2 clear");
    @(negedge clk) chg_en = 1'b0; #1;
    chk(chg_on, 1'b0, "R10 normal gate");
    @(negedge clk) chg_en = 1'b1;
    // R7 priority, R6 sleep
    ov[0] = 1; ovr[0] = 1; uv[2] = 1; uvr[2] = 0;
    sample("R7 a"); sample("R7 b");
    chk(slp, 1'b1, "R7 uv wins");
    chk(dsg_on, 1'b0, "R6 dsg off");
    chk(chg_on, 1'b0, "R6 chg off");
    // R8 ticks ignored in sleep, wake burst
    clear_flags();
    sample("R8 tick ignored");
    chk(slp, 1'b1, "R8 still asleep");
    uvr[2] = 0;
    do_wake("R8 wake");
    chk(dsg_on, 1'b1, "R8 burst dsg");
    // R9 burst end
    sample("R9 to sleep");
    chk(slp, 1'b1, "R9 back asleep");
    uvr = '1;
    do_wake("R9 wake again");
    sample("R9 to normal");
    chk(slp, 1'b0, "R9 normal");
    sample("R9 stays normal");

    // random phase
    for (int it = 0; it < 250; it++) begin
      for (int c = 0; c < NC; c++) begin
        ov[c]  = ($urandom_range(7) == 0);
        ovr[c] = ov[c] | ($urandom_range(3) == 0);
        uv[c]  = ($urandom_range(15) == 0);
        uvr[c] = !uv[c] && ($urandom_range(3) != 0);
      end
      cnt3   = $urandom_range(1);
      chg_en = ($urandom_range(7) != 0);
      sense  = $urandom_range(1);
      if (m_st == 2 && $urandom_range(1) == 1) do_wake("R8 random wake");
      sample("R10 random");
    end

    // R11 prescaler
    clear_flags(); cnt3 = 0; chg_en = 1; sense = 0;
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    m_st = 0; m_uv = 0; m_ov = 0;
    ov[0] = 1; ovr[0] = 1;
    repeat (PS + 20) @(negedge clk);
    chk(chg_on, 1'b1, "R11 one period");
    repeat (PS) @(negedge clk);
    chk(chg_on, 1'b0, "R11 two periods");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule